// File: doc/BRIEF.md
# Floating-Point Add/Subtract by Magnitude

This unit takes a floating-point accumulator value and a second floating-point operand and adds or subtracts them over several clock cycles. Each value has a sign-magnitude fraction (one sign bit and a 39-bit magnitude) and a separate 16-bit two's-complement exponent. The fraction's magnitude bit 38 is its most significant bit and has weight one half. When the magnitude-mode input is set, the operand's sign is forced positive before the add or subtract, so the operation uses the operand's absolute value.

A single-cycle `start` pulse loads both values. Before any alignment, the unit shifts both fractions right by one place and raises both exponents by one. This guarantees that combining the fractions can never carry out of 39 bits. Alignment then moves one bit per clock: the fraction with the smaller exponent shifts right and its exponent rises by one. Alignment ends when the exponents match or when either fraction magnitude is zero. The fractions are then combined in sign-magnitude form. The result is normalised by shifting it left one bit per clock, lowering the exponent by one each time. Normalisation ends when magnitude bit 38 is set or the magnitude is zero. `done` then pulses for one cycle, and the result stays on the outputs until the next start.

Top module: `fmag_addsub`

## Requirements
- R1: After reset, `busy`, `done`, `res_sign`, `res_frac` and `res_exp` are all 0. A `start` sampled while idle begins an operation and raises `busy` on the next cycle. A `start` sampled while `busy` is high has no effect on the result.
- R2: With `mag_mode`=1 the operand sign is treated as 0 (positive) whatever `opd_sign` is. With `mag_mode`=0, `opd_sign` is used as given.
- R3: With `sub_sel`=1 the operand, after R2 is applied, is subtracted from the accumulator. With `sub_sel`=0 it is added.
- R4: In the cycle after start, both fraction magnitudes shift right by one and both exponents increase by 1. Because of this, the combine step never carries out of 39 bits, even when both magnitudes are all ones.
- R5: Alignment performs one step per clock cycle. When the accumulator exponent is less than the operand exponent, the accumulator fraction shifts right and its exponent increases by 1. When it is greater, the operand fraction shifts right and the operand exponent increases by 1. Alignment ends when the two exponents are equal.
- R6: Alignment also ends as soon as either fraction magnitude is zero. If the accumulator magnitude is zero at the combine step, the result exponent is the operand's current exponent.
- R7: If the effective signs are equal, the magnitudes are added and the common sign is kept. If they differ, the smaller magnitude is subtracted from the larger one, and the result takes the sign of the larger. On a tie, the result takes the accumulator sign.
- R8: A non-zero result shifts left one bit per clock, and the exponent decreases by 1 per shift, until magnitude bit 38 is 1. The total time from the start edge to `done` is 4 cycles, plus one cycle per alignment step, plus one cycle per normalisation shift.
- R9: A zero result magnitude ends normalisation at once and gives `res_sign`=0.
- R10: `done` is high for exactly one cycle, with `busy` low, as the operation ends. The result outputs then hold steady until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| sub_sel | input | 1 | 1 = subtract operand, 0 = add |
| mag_mode | input | 1 | 1 = force operand sign positive |
| acc_sign | input | 1 | Accumulator fraction sign |
| acc_frac | input | 39 | Accumulator fraction magnitude |
| acc_exp | input | 16 | Accumulator exponent, two's complement |
| opd_sign | input | 1 | Operand fraction sign |
| opd_frac | input | 39 | Operand fraction magnitude |
| opd_exp | input | 16 | Operand exponent, two's complement |
| res_sign | output | 1 | Result sign |
| res_frac | output | 39 | Result fraction magnitude |
| res_exp | output | 16 | Result exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest path to reach is the one where alignment shifts a fraction all the way to zero before the exponents meet. When this happens to the accumulator, the result must take the operand's exponent, not the accumulator's partly raised one. The stimulus reaches this path by applying exponent gaps larger than the fraction width in both directions, and by applying a zero accumulator fraction. A start pulse applied in the middle of a long alignment checks that a request arriving while busy leaves the result untouched. Latency is compared against the step counts that the bench's own model predicts.

// File: rtl/fmag_addsub.sv
module fmag_addsub #(
  parameter int FW = 39,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sub_sel,
  input  logic          mag_mode,
  input  logic          acc_sign,
  input  logic [FW-1:0] acc_frac,
  input  logic [EW-1:0] acc_exp,
  input  logic          opd_sign,
  input  logic [FW-1:0] opd_frac,
  input  logic [EW-1:0] opd_exp,
  output logic          res_sign,
  output logic [FW-1:0] res_frac,
  output logic [EW-1:0] res_exp,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ALIGN, S_COMB, S_NORM} st_t;

  st_t                 st;
  logic                a_s, b_s;
  logic [FW-1:0]       a_m, b_m;
  logic signed [EW-1:0] r_e, x_e;

  logic [FW:0]   sum_w;
  logic          a_ge;
  logic          align_end;

  assign sum_w     = {1'b0, a_m} + {1'b0, b_m};
  assign a_ge      = a_m >= b_m;
  assign align_end = (a_m == '0) || (b_m == '0) || (r_e == x_e);

  assign busy     = st != S_IDLE;
  assign res_sign = a_s;
  assign res_frac = a_m;
  assign res_exp  = r_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      a_s  <= 1'b0;
      b_s  <= 1'b0;
      a_m  <= '0;
      b_m  <= '0;
      r_e  <= '0;
      x_e  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          a_s <= acc_sign;
          a_m <= acc_frac;
          r_e <= acc_exp;
          b_s <= (opd_sign & ~mag_mode) ^ sub_sel;
          b_m <= opd_frac;
          x_e <= opd_exp;
          st  <= S_PRE;
        end
        S_PRE: begin
          a_m <= a_m >> 1;
          b_m <= b_m >> 1;
          r_e <= r_e + 1'b1;
          x_e <= x_e + 1'b1;
          st  <= S_ALIGN;
        end
        S_ALIGN: begin
          if (align_end) st <= S_COMB;
          else if (r_e < x_e) begin
            a_m <= a_m >> 1;
            r_e <= r_e + 1'b1;
          end else begin
            b_m <= b_m >> 1;
            x_e <= x_e + 1'b1;
          end
        end
        S_COMB: begin
          if (a_m == '0) r_e <= x_e;
          if (a_s == b_s) a_m <= sum_w[FW-1:0];
          else if (a_ge) a_m <= a_m - b_m;
          else begin
            a_m <= b_m - a_m;
            a_s <= b_s;
          end
          st <= S_NORM;
        end
        S_NORM: begin
          if (a_m == '0) begin
            a_s  <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (a_m[FW-1]) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            a_m <= a_m << 1;
            r_e <= r_e - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_pre_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |=> (r_e == $past(r_e) + 1'b1) && (x_e == $past(x_e) + 1'b1)
                      && (a_m[FW-1] == 1'b0) && (b_m[FW-1] == 1'b0));

  p_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COMB) |-> !sum_w[FW]);

  p_align_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ALIGN && !align_end) |=>
      ((r_e == $past(r_e) + 1'b1) && (x_e == $past(x_e))) ||
      ((x_e == $past(x_e) + 1'b1) && (r_e == $past(r_e))));

  p_norm_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NORM && a_m != '0 && !a_m[FW-1]) |=>
      (r_e == $past(r_e) - 1'b1) && (a_m == {$past(a_m[FW-2:0]), 1'b0}));

  p_norm_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_frac != '0) |-> res_frac[FW-1]);

  p_zero_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_frac == '0) |-> !res_sign);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$rose(done) && !$past(start)) |-> $stable(res_frac) && $stable(res_exp));

endmodule

// File: tb/fmag_addsub_tb_top.sv
module fmag_addsub_tb_top;
  localparam int FW = 39;
  localparam int EW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, sub_sel, mag_mode, acc_sign, opd_sign;
  logic [FW-1:0] acc_frac, opd_frac;
  logic [EW-1:0] acc_exp, opd_exp;
  logic res_sign, busy, done;
  logic [FW-1:0] res_frac;
  logic [EW-1:0] res_exp;

  fmag_addsub #(.FW(FW), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sub_sel(sub_sel), .mag_mode(mag_mode),
    .acc_sign(acc_sign), .acc_frac(acc_frac), .acc_exp(acc_exp),
    .opd_sign(opd_sign), .opd_frac(opd_frac), .opd_exp(opd_exp),
    .res_sign(res_sign), .res_frac(res_frac), .res_exp(res_exp),
    .busy(busy), .done(done));

  typedef struct {
    logic          s;
    logic [FW-1:0] m;
    logic [EW-1:0] e;
    int            lat;
    int            t0;
    string         tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model(input logic as, input logic [FW-1:0] af, input logic [EW-1:0] ae,
                       input logic os, input logic [FW-1:0] of, input logic [EW-1:0] oe,
                       input logic sub, input logic mag, output item_t it);
    logic [FW-1:0] a, b;
    logic signed [EW-1:0] r, x;
    logic sa, sb;
    logic [FW:0] sm;
    int n, k;
    a = af >> 1; b = of >> 1; r = ae + 1'b1; x = oe + 1'b1;
    sa = as; sb = (mag ? 1'b0 : os) ^ sub;
    n = 0; k = 0;
    while (a != 0 && b != 0 && r != x) begin
      if (r < x) begin a = a >> 1; r = r + 1'b1; end
      else begin b = b >> 1; x = x + 1'b1; end
      n++;
    end
    if (a == 0) r = x;
    if (sa == sb) begin sm = a + b; a = sm[FW-1:0]; end
    else if (a >= b) a = a - b;
    else begin a = b - a; sa = sb; end
    if (a == 0) sa = 1'b0;
    else while (!a[FW-1]) begin a = a << 1; r = r - 1'b1; k++; end
    it.s = sa; it.m = a; it.e = r; it.lat = n + 4 + k;
  endtask

  task automatic op(input logic as, input logic [FW-1:0] af, input logic [EW-1:0] ae,
                    input logic os, input logic [FW-1:0] of, input logic [EW-1:0] oe,
                    input logic sub, input logic mag, input string tag);
    item_t it;
    while (busy) @(negedge clk);
    acc_sign = as; acc_frac = af; acc_exp = ae;
    opd_sign = os; opd_frac = of; opd_exp = oe;
    sub_sel = sub; mag_mode = mag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model(as, af, ae, os, of, oe, sub, mag, it);
    it.t0 = cyc; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done && prev_done) check("R10 done longer than one cycle", 1, 0);
        if (done) begin
          check("R10 busy low with done", busy, 0);
          if (q.size() == 0) check("R10 unexpected done", 1, 0);
          else begin
            item_t it;
            it = q.pop_front();
            check({it.tag, " sign"}, res_sign, it.s);
            check({it.tag, " frac"}, res_frac, it.m);
            check({it.tag, " exp"}, res_exp, it.e);
            check({it.tag, " latency R8"}, cyc - it.t0, it.lat);
          end
        end
        prev_done = done;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=busy expected=idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  localparam logic [FW-1:0] HALF = 39'h40_0000_0000;
  localparam logic [FW-1:0] QTR  = 39'h20_0000_0000;
  localparam logic [FW-1:0] ONES = {FW{1'b1}};

  initial begin
    logic [63:0] w1, w2;
    logic [FW-1:0] hold_m;
    logic [EW-1:0] hold_e;
    rst_n = 1'b0; start = 1'b0; sub_sel = 1'b0; mag_mode = 1'b0;
    acc_sign = 1'b0; acc_frac = '0; acc_exp = '0;
    opd_sign = 1'b0; opd_frac = '0; opd_exp = '0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R1 reset frac", res_frac, 0);
    check("R1 reset exp", res_exp, 0);
    check("R1 reset sign", res_sign, 0);
    rst_n = 1'b1;
    @(negedge clk);

    op(0, HALF, 16'd0, 0, QTR, 16'd0, 0, 0, "R7 add equal exps");
    op(0, HALF, 16'd2, 0, HALF, 16'd5, 0, 0, "R5 acc exp smaller");
    op(1, 39'h55_5555_5555, 16'd9, 1, QTR, 16'd3, 0, 0, "R5 opd exp smaller");
    op(0, HALF, 16'd4, 0, HALF, 16'd4, 1, 0, "R9 subtract to zero");
    op(0, HALF, 16'd1, 1, QTR, 16'd1, 1, 1, "R2 mag forces positive then R3 sub");
    op(0, HALF, 16'd1, 1, QTR, 16'd1, 0, 0, "R2 signed operand add");
    op(0, QTR, 16'd0, 0, HALF, 16'd0, 1, 0, "R3 R7 larger operand wins sign");
    op(1, 39'h0, 16'd7, 0, 39'h12_3456_789A, 16'hFFF0, 0, 0, "R6 acc zero takes opd exp");
    op(0, 39'h31_0000_0001, 16'hFFFB, 0, 39'h0, 16'd20, 0, 0, "R6 opd zero");
    op(0, HALF, 16'd0, 0, HALF, 16'd60, 0, 0, "R6 acc shifted to zero");
    op(1, HALF, 16'd70, 0, ONES, 16'd0, 0, 0, "R6 opd shifted to zero");
    op(0, ONES, 16'd3, 0, ONES, 16'd3, 0, 0, "R4 max magnitudes no carry");
    op(1, 39'h00_0000_0001, 16'hFFF8, 1, 39'h00_0000_0003, 16'hFFF6, 0, 0, "R8 long normalise");
    op(0, HALF, 16'd3, 0, HALF, 16'd3, 1, 1, "R9 mag sub equal");

    op(0, QTR, 16'd0, 0, QTR, 16'd40, 0, 0, "R1 start while busy ignored");
    repeat (3) @(negedge clk);
    acc_sign = 1'b1; acc_frac = ONES; acc_exp = 16'd100; opd_frac = 39'h1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    for (int i = 0; i < 24; i++) begin
      w1 = {$urandom, $urandom};
      w2 = {$urandom, $urandom};
      op(w1[63], w1[FW-1:0], EW'($signed(w1[45:40] & 6'h3F) - 32), w2[63], w2[FW-1:0],
         EW'($signed(w2[45:40] & 6'h3F) - 32), w1[50], w2[50], "R7 mixed pattern");
    end

    while (busy || q.size() != 0) @(negedge clk);
    hold_m = res_frac; hold_e = res_exp;
    repeat (4) @(negedge clk);
    check("R10 result held frac", res_frac, hold_m);
    check("R10 result held exp", res_exp, hold_e);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule